// File: doc/BRIEF.md
# Byte-Wide Parallel EEPROM Access Controller

This block lets a host read and write single bytes of a 2 KB parallel EEPROM. The EEPROM has an 11-bit address and an 8-bit data bus that carries data in both directions. The host offers one request at a time on a valid/ready channel. A request carries a direction flag, an address and, for stores, a data byte. The controller registers the request and sequences the active-low output-enable and write-enable strobes. It also steers the data bus direction. When the access is over, it returns a one-cycle completion pulse, which on a read comes with the captured byte.

The write-enable low pulse has a legal window of 100 ns to 1000 ns. Its length is a parameter counted in system clocks. Elaboration stops when that count times the clock period falls outside the window. On a write, the data bus is driven one or more clocks before write-enable falls and stays driven for one or more clocks after it rises. On a read, the bus is released, output-enable falls, and the byte is sampled after a programmable number of clocks. Every access ends with one idle recovery clock before the completion pulse.

The data bus reaches the chip-level pad as three plain signals: an output byte, an output enable and an input byte. The bidirectional pad cell sits outside the block.

Back-pressure works as follows. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The host must hold its fields steady while `req_valid` is high and `req_ready` is low. The completion pulse cannot be stalled.

Top module: `eeprom_port_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, before any request: `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1, `rsp_valid`=0, `rsp_rdata`=0.
- R2: A request is accepted on a clock edge with `req_valid`=1 and `req_ready`=1. `req_ready` is then low until the cycle that carries the completion pulse. A request presented while `req_ready` is low is not taken and waits until `req_ready` returns.
- R3: A write drives `mem_we_n` low for exactly `WE_PULSE_CLKS` consecutive clocks (10 clocks, 200 ns at 50 MHz by default). Elaboration fails if `WE_PULSE_CLKS*CLK_PERIOD_NS` is below 100 or above 1000.
- R4: During a write, `mem_oe_n` stays 1. `mem_dq_oe` is 1 for `SETUP_CLKS` clocks before `mem_we_n` falls, all through the low pulse, and for `HOLD_CLKS` clocks after it rises. `mem_dq_out` carries the request's byte throughout.
- R5: During a read, `mem_dq_oe` is 0 and `mem_we_n` is 1. `mem_oe_n` is low for exactly `ACCESS_CLKS` clocks, and the byte on `mem_dq_in` at the last of those edges is returned.
- R6: Address and write data are registered when the request is accepted. `mem_addr` and `mem_dq_out` stay stable for the whole access, whatever `req_addr` and `req_wdata` do afterwards.
- R7: Every access ends with one recovery clock in which both strobes are 1 and `mem_dq_oe` is 0. The next cycle carries a single-cycle `rsp_valid` with `req_ready`=1. `rsp_rdata` holds the last read byte until the next read completes; a write leaves it unchanged.
- R8: `rsp_valid` appears `SETUP_CLKS+WE_PULSE_CLKS+HOLD_CLKS+1` clock edges after a write is accepted, and `ACCESS_CLKS+1` edges after a read is accepted. A new request may be accepted on the edge that ends the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = store byte, 0 = fetch byte |
| req_addr | input | ADDR_W (11) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to store |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Last byte fetched |
| mem_addr | output | ADDR_W (11) | Address lines to the device |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_dq_out | output | DATA_W (8) | Byte driven toward the device |
| mem_dq_oe | output | 1 | Pad driver enable for the data lines |
| mem_dq_in | input | DATA_W (8) | Byte seen on the data lines |

## Verification
The first pattern stores a distinct arithmetic byte at every one of the 2048 addresses back-to-back, with `req_valid` held high. Every address is then fetched. This separates address decoding faults and stuck data bits from sequencing faults, and it checks that a waiting request is held off while the controller is busy.

The second pattern writes complemented bytes to sparse addresses, each immediately followed by a read of the same address and separated by idle gaps. This shows that a store takes effect before the following fetch, and that the idle pins are correct.

Every cycle of every access is compared against a strobe trace computed from the timing parameters. The behavioural memory measures each write pulse in nanoseconds. A fetch followed by a store shows that the returned byte survives the store.

// File: rtl/eeprom_ctrl_pkg.sv
`timescale 1ns/1ps
package eeprom_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSET  = 3'd1,
    PH_WLOW  = 3'd2,
    PH_WHOLD = 3'd3,
    PH_RACC  = 3'd4,
    PH_GAP   = 3'd5
  } phase_t;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/eeprom_phase_timer.sv
`timescale 1ns/1ps
module eeprom_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eeprom_seq.sv
`timescale 1ns/1ps
module eeprom_seq
  import eeprom_ctrl_pkg::*;
#(
  parameter int SETUP_CLKS    = 1,
  parameter int WE_PULSE_CLKS = 10,
  parameter int HOLD_CLKS     = 1,
  parameter int ACCESS_CLKS   = 4,
  parameter int CW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic          expired,
  output phase_t        phase_q,
  output phase_t        phase_n,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          capture,
  output logic          finish
);

  localparam logic [CW-1:0] LEN_SET = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] LEN_LOW = CW'(WE_PULSE_CLKS - 1);
  localparam logic [CW-1:0] LEN_HLD = CW'(HOLD_CLKS - 1);
  localparam logic [CW-1:0] LEN_ACC = CW'(ACCESS_CLKS - 1);

  always_comb begin
    phase_n  = phase_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    finish   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (start_wr) begin
            phase_n  = PH_WSET;
            load_val = LEN_SET;
          end else begin
            phase_n  = PH_RACC;
            load_val = LEN_ACC;
          end
        end
      end
      PH_WSET: begin
        if (expired) begin
          phase_n  = PH_WLOW;
          load     = 1'b1;
          load_val = LEN_LOW;
        end
      end
      PH_WLOW: begin
        if (expired) begin
          phase_n  = PH_WHOLD;
          load     = 1'b1;
          load_val = LEN_HLD;
        end
      end
      PH_WHOLD: begin
        if (expired) begin
          phase_n = PH_GAP;
          load    = 1'b1;
        end
      end
      PH_RACC: begin
        if (expired) begin
          phase_n = PH_GAP;
          load    = 1'b1;
          capture = 1'b1;
        end
      end
      PH_GAP: begin
        phase_n = PH_IDLE;
        finish  = 1'b1;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_n;
  end

endmodule

// File: rtl/eeprom_io_regs.sv
`timescale 1ns/1ps
module eeprom_io_regs
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase_n,
  input  logic              capture,
  input  logic              finish,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // request registers: captured once, held for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // strobes come straight from flops so they cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_we_n  <= (phase_n != PH_WLOW);
      mem_oe_n  <= (phase_n != PH_RACC);
      mem_dq_oe <= (phase_n == PH_WSET) || (phase_n == PH_WLOW) ||
                   (phase_n == PH_WHOLD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/eeprom_port_ctrl.sv
`timescale 1ns/1ps
module eeprom_port_ctrl
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int WE_PULSE_CLKS = 10,
  parameter int SETUP_CLKS    = 1,
  parameter int HOLD_CLKS     = 1,
  parameter int ACCESS_CLKS   = 4,
  parameter int WE_MIN_NS     = 100,
  parameter int WE_MAX_NS     = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int PULSE_NS = WE_PULSE_CLKS * CLK_PERIOD_NS;
  localparam int MAX_LEN  = max_of4(SETUP_CLKS, WE_PULSE_CLKS, HOLD_CLKS, ACCESS_CLKS);
  localparam int CW       = $clog2(MAX_LEN + 1);

  generate
    if (PULSE_NS < WE_MIN_NS || PULSE_NS > WE_MAX_NS) begin : g_bad_pulse
      $error("write pulse of %0d ns lies outside %0d..%0d ns", PULSE_NS, WE_MIN_NS, WE_MAX_NS);
    end
    if (SETUP_CLKS < 1 || HOLD_CLKS < 1 || ACCESS_CLKS < 1) begin : g_bad_phase
      $error("setup, hold and access counts must each be at least one clock");
    end
  endgenerate

  phase_t          phase_q;
  phase_t          phase_n;
  logic            accept;
  logic            t_load;
  logic [CW-1:0]   t_val;
  logic            t_expired;
  logic            capture;
  logic            finish;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  eeprom_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  eeprom_seq #(
    .SETUP_CLKS    (SETUP_CLKS),
    .WE_PULSE_CLKS (WE_PULSE_CLKS),
    .HOLD_CLKS     (HOLD_CLKS),
    .ACCESS_CLKS   (ACCESS_CLKS),
    .CW            (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .expired  (t_expired),
    .phase_q  (phase_q),
    .phase_n  (phase_n),
    .load     (t_load),
    .load_val (t_val),
    .capture  (capture),
    .finish   (finish)
  );

  eeprom_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .phase_n    (phase_n),
    .capture    (capture),
    .finish     (finish),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/eeprom_port_ctrl_chk.sv
`timescale 1ns/1ps
module eeprom_port_ctrl_chk #(
  parameter int ADDR_W        = 11,
  parameter int WE_PULSE_CLKS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic [15:0] low_run;
  logic        strobing;

  assign strobing = !mem_oe_n || !mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (!mem_we_n) low_run <= low_run + 16'd1;
    else                low_run <= '0;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_run == 16'(WE_PULSE_CLKS)));

  // R4
  we_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && $past(strobing)) |-> $stable(mem_addr));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind eeprom_port_ctrl eeprom_port_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .WE_PULSE_CLKS (WE_PULSE_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_eeprom_port_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_port_ctrl;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TCLK  = 20;
  localparam int S     = 1;
  localparam int W     = 10;
  localparam int H     = 1;
  localparam int A     = 4;
  localparam int WLAST = S + W + H + 2;
  localparam int RLAST = A + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_oe_n;
  logic          mem_we_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  always #(TCLK/2) clk = ~clk;

  eeprom_port_ctrl #(
    .CLK_PERIOD_NS (TCLK),
    .WE_PULSE_CLKS (W),
    .SETUP_CLKS    (S),
    .HOLD_CLKS     (H),
    .ACCESS_CLKS   (A)
  ) i_eeprom_port_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 13 + (a >> 3)) ^ 8'hA5;
  endfunction

  // behavioural device: drives when output-enabled, stores on write-enable rise
  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  realtime       t_fall;

  assign mem_dq_in = (!mem_oe_n && mem_we_n) ? mem[mem_addr] : '0;

  always @(negedge mem_we_n) t_fall = $realtime;

  always @(posedge mem_we_n) begin
    if (rst_n) begin
      // R3 pulse width measured in nanoseconds
      chk(($realtime - t_fall) >= 100.0 && ($realtime - t_fall) <= 1000.0,
          "R3 write pulse ns", int'($realtime - t_fall), W * TCLK);
      mem[mem_addr] <= mem_dq_out;
    end
  end

  // cycle-by-cycle trace monitor, sampled on the falling edge
  bit            act = 1'b0;
  bit            op_wr;
  int            k;
  logic [AW-1:0] op_a;
  logic [DW-1:0] op_d;

  always @(negedge clk) begin
    if (rst_n) begin
      if (act) begin
        logic e_we, e_oe, e_doe;
        int   last;
        k++;
        if (op_wr) begin
          e_we  = !(k > S && k <= S + W);
          e_oe  = 1'b1;
          e_doe = (k <= S + W + H);
          last  = WLAST;
        end else begin
          e_we  = 1'b1;
          e_oe  = !(k <= A);
          e_doe = 1'b0;
          last  = RLAST;
        end
        chk({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} ==
            {e_we, e_oe, e_doe, k == last, k == last},
            op_wr ? "R2 R3 R4 R7 R8 write trace" : "R2 R5 R7 R8 read trace",
            int'({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}),
            int'({e_we, e_oe, e_doe, k == last, k == last}));
        if (k < last)
          chk(mem_addr == op_a, "R6 address held", int'(mem_addr), int'(op_a));
        if (op_wr && e_doe)
          chk(mem_dq_out == op_d, "R6 write data held", int'(mem_dq_out), int'(op_d));
        if (k == last) begin
          act = 1'b0;
          if (!op_wr)
            chk(rsp_rdata == shadow[op_a], "R5 R7 fetched byte", int'(rsp_rdata), int'(shadow[op_a]));
        end
      end else begin
        chk({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} == 5'b11010,
            "R1 R7 idle pins", int'({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);
      end
      if (req_valid && req_ready) begin
        act   = 1'b1;
        k     = 0;
        op_wr = req_write;
        op_a  = req_addr;
        op_d  = req_wdata;
        if (req_write) shadow[req_addr] = req_wdata;
      end
    end
  end

  // drives at posedge + 2 ns; scrambles the fields after acceptance (R6)
  task automatic op(input bit wr, input int a, input logic [DW-1:0] d, input bit keep);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = d;
    while (!req_ready) begin
      @(posedge clk); #2;
    end
    @(posedge clk); #2;
    req_addr  = ~AW'(a);
    req_wdata = ~d;
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic settle();
    req_valid = 1'b0;
    repeat (WLAST + 3) @(posedge clk);
    #2;
  endtask

  initial begin
    #(150000 * TCLK);
    bad++;
    $display("FAIL watchdog expired after %0d checks", total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = '0;
      shadow[i] = '0;
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 pins under reset
    chk({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} == 5'b11010, "R1 reset pins",
        int'({mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}), 5'b11010);
    chk(rsp_rdata == '0, "R1 reset read byte", int'(rsp_rdata), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;

    // pattern 1: back-to-back stores to every address, valid held high (R2)
    for (int a = 0; a < DEPTH; a++) op(1'b1, a, pat(a), 1'b1);
    settle();
    for (int a = 0; a < DEPTH; a++) op(1'b0, a, '0, 1'b1);
    settle();

    // pattern 2: sparse complemented stores, each read back after it, idle gaps
    for (int a = 3; a < DEPTH; a += 37) begin
      op(1'b1, a, ~pat(a), 1'b0);
      op(1'b0, a, '0, 1'b0);
      repeat (3) @(posedge clk); #2;
    end
    settle();

    // extremes: all-zero and all-one bytes at the first and last address
    op(1'b1, 0, 8'h00, 1'b0);
    op(1'b1, DEPTH - 1, 8'hFF, 1'b0);
    op(1'b0, DEPTH - 1, '0, 1'b0);
    op(1'b0, 0, '0, 1'b0);
    settle();

    // R7: fetched byte survives a following store
    op(1'b0, 5, '0, 1'b0);
    settle();
    op(1'b1, 6, ~rsp_rdata, 1'b0);
    settle();
    chk(rsp_rdata == shadow[5], "R7 read byte kept over store", int'(rsp_rdata), int'(shadow[5]));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule